// File: doc/BRIEF.md
# Edge Timetagger with Glitch Filter

This block watches a small group of digital inputs. It removes short glitches from each one and detects rising and falling transitions on the cleaned signals. For every transition whose polarity is enabled, it emits one 64-bit message. The message carries the channel, the polarity, the cleaned state of all inputs and a 48-bit timestamp. The timestamp comes from a free-running counter outside the block, which advances once per clock cycle (8 ns). Software can also ask for a marker message, which records the current input state and time.

Output is a valid/ready stream of 64-bit words that feeds a downstream FIFO. Transitions on several channels in the same cycle are held as one batch. The batch is then sent out as separate words, one at a time. A second batch can wait behind the one being sent, so short bursts of activity survive backpressure. The inputs are assumed to be synchronous to the clock already.

Top module: `edge_stamper`

## Requirements
- R1: While reset is asserted, and after its release with no input activity, `m_valid` is low.
- R2: A level on an input that holds for fewer than FILT_LEN consecutive clock samples produces no message and leaves the filtered state unchanged.
- R3: A new level held for exactly FILT_LEN consecutive samples is accepted. A pulse of FILT_LEN cycles yields both its rising and its falling message.
- R4: Enable bit 2k lets rising transitions of input k through, and bit 2k+1 lets falling transitions through. A transition whose bit is 0 produces no message, but it still updates the filtered state.
- R5: An event word has 4'h2 in bits 63:60, the channel index in bits 59:57, bit 56 set for a falling and clear for a rising transition, and zero in bits 55:52.
- R6: The stamp in bits 47:0 is the timestamp input value seen FILT_LEN cycles after the cycle in which the new raw level is first presented.
- R7: Transitions accepted in the same cycle each give their own word, in ascending channel order. All of these words carry the same stamp and the same state field.
- R8: A marker word has 8'h30 in bits 63:56, zero in bits 55:52, the filtered state in bits 51:48, and the timestamp of the cycle in which `mark_req` was high. A marker taken in the same cycle as events follows those events.
- R9: One further batch is held while a batch is being sent, and it is sent afterwards with its own stamp. A batch that arrives while both are occupied is dropped whole.
- R10: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_data` stays unchanged.
- R11: Bits 51:48 give the filtered input state after the event, zero-extended to four bits. In an event word, the bit for that channel equals 1 for a rising and 0 for a falling transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timestamp unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | NUM_CH | Raw digital inputs, synchronous to clk |
| edge_en | input | 2*NUM_CH | Per-channel, per-polarity enable mask |
| mark_req | input | 1 | One-cycle request for a marker word |
| ts_now | input | TS_W | Free-running timestamp counter value |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the word |
| m_data | output | 64 | Event or marker word |

## Verification
The case hardest to reach from the ports is having both the word being sent and the waiting batch occupied when a third batch arrives. Only in that state is a batch dropped. The stimulus holds `m_ready` low and applies three separate transitions, each held long enough to pass the filter. The third batch must vanish while the first two come out in order with their own stamps once `m_ready` rises. The dropped transition must still show up in the state field of a later word. Glitches of every length below the filter threshold are also applied, followed by a marker that proves the filtered state did not move.

// File: rtl/edge_stamper_pkg.sv
package edge_stamper_pkg;
   localparam int          MSG_W     = 64;
   localparam int          TS_FW     = 48;
   localparam int          STATE_FW  = 4;
   localparam int          CHIDX_FW  = 3;
   localparam logic [3:0]  EVT_TAG   = 4'h2;
   localparam logic [7:0]  MRK_TAG   = 8'h30;

   function automatic logic [MSG_W-1:0] pack_event(
      input logic [CHIDX_FW-1:0] ch,
      input logic                is_fall,
      input logic [STATE_FW-1:0] st,
      input logic [TS_FW-1:0]    ts);
      return {EVT_TAG, ch, is_fall, 4'b0000, st, ts};
   endfunction

   function automatic logic [MSG_W-1:0] pack_marker(
      input logic [STATE_FW-1:0] st,
      input logic [TS_FW-1:0]    ts);
      return {MRK_TAG, 4'b0000, st, ts};
   endfunction
endpackage

// File: rtl/es_deglitch.sv
module es_deglitch #(
   parameter int FILT_LEN = 4
)(
   input  logic clk,
   input  logic rst_n,
   input  logic raw,
   output logic level,
   output logic rise,
   output logic fall
);
   generate
      if (FILT_LEN <= 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= 1'b0;
               rise  <= 1'b0;
               fall  <= 1'b0;
            end else begin
               rise  <= raw & ~level;
               fall  <= ~raw & level;
               level <= raw;
            end
         end
      end else begin : g_count
         localparam int CNT_W = $clog2(FILT_LEN);
         localparam logic [CNT_W-1:0] LAST = CNT_W'(FILT_LEN - 1);
         logic [CNT_W-1:0] run;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               level <= 1'b0;
               rise  <= 1'b0;
               fall  <= 1'b0;
               run   <= '0;
            end else if (raw == level) begin
               run  <= '0;
               rise <= 1'b0;
               fall <= 1'b0;
            end else if (run == LAST) begin
               level <= raw;
               run   <= '0;
               rise  <= raw;
               fall  <= ~raw;
            end else begin
               run  <= run + CNT_W'(1);
               rise <= 1'b0;
               fall <= 1'b0;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/es_capture.sv
module es_capture #(
   parameter int NUM_CH = 4,
   parameter int TS_W   = 48
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_CH-1:0]     rise,
   input  logic [NUM_CH-1:0]     fall,
   input  logic [NUM_CH-1:0]     lvl,
   input  logic [2*NUM_CH-1:0]   edge_en,
   input  logic                  mark_req,
   input  logic [TS_W-1:0]       ts_now,
   input  logic                  take,
   output logic                  bat_v,
   output logic [2*NUM_CH:0]     bat_mask,
   output logic [TS_W-1:0]       bat_ts,
   output logic [NUM_CH-1:0]     bat_state
);
   localparam int SLOT_W = 2*NUM_CH + 1;

   logic [SLOT_W-1:0] new_mask;
   logic              new_v;
   logic              cap_v;
   logic [SLOT_W-1:0] cap_mask;
   logic [TS_W-1:0]   cap_ts;
   logic [NUM_CH-1:0] cap_state;

   always_comb begin
      for (int k = 0; k < NUM_CH; k++) begin
         new_mask[2*k]   = rise[k] & edge_en[2*k];
         new_mask[2*k+1] = fall[k] & edge_en[2*k+1];
      end
      new_mask[SLOT_W-1] = mark_req;
   end

   assign new_v     = |new_mask;
   assign bat_v     = cap_v | new_v;
   assign bat_mask  = cap_v ? cap_mask  : new_mask;
   assign bat_ts    = cap_v ? cap_ts    : ts_now;
   assign bat_state = cap_v ? cap_state : lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_v     <= 1'b0;
         cap_mask  <= '0;
         cap_ts    <= '0;
         cap_state <= '0;
      end else if (take) begin
         if (cap_v) begin
            cap_v     <= new_v;
            cap_mask  <= new_mask;
            cap_ts    <= ts_now;
            cap_state <= lvl;
         end
      end else if (!cap_v && new_v) begin
         cap_v     <= 1'b1;
         cap_mask  <= new_mask;
         cap_ts    <= ts_now;
         cap_state <= lvl;
      end
   end
endmodule

// File: rtl/es_serial.sv
module es_serial
   import edge_stamper_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int TS_W   = 48
)(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bat_v,
   input  logic [2*NUM_CH:0]     bat_mask,
   input  logic [TS_W-1:0]       bat_ts,
   input  logic [NUM_CH-1:0]     bat_state,
   output logic                  take,
   output logic                  m_valid,
   input  logic                  m_ready,
   output logic [MSG_W-1:0]      m_data
);
   localparam int SLOT_W = 2*NUM_CH + 1;
   localparam int IDX_W  = $clog2(SLOT_W);
   localparam logic [IDX_W-1:0] MRK_IDX = IDX_W'(SLOT_W - 1);

   logic              work_v;
   logic [SLOT_W-1:0] work_mask;
   logic [TS_W-1:0]   work_ts;
   logic [NUM_CH-1:0] work_state;
   logic [SLOT_W-1:0] pick;
   logic [SLOT_W-1:0] rest;
   logic [IDX_W-1:0]  idx;
   logic              acc;
   logic              last;

   assign pick = work_mask & (~work_mask + SLOT_W'(1));
   assign rest = work_mask & ~pick;
   assign last = (rest == '0);
   assign acc  = work_v & m_ready;
   assign take = ~work_v | (acc & last);

   always_comb begin
      idx = '0;
      for (int i = SLOT_W-1; i >= 0; i--) begin
         if (work_mask[i]) idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (idx == MRK_IDX)
         m_data = pack_marker(STATE_FW'(work_state), TS_FW'(work_ts));
      else
         m_data = pack_event(CHIDX_FW'(idx >> 1), idx[0],
                             STATE_FW'(work_state), TS_FW'(work_ts));
   end

   assign m_valid = work_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         work_v     <= 1'b0;
         work_mask  <= '0;
         work_ts    <= '0;
         work_state <= '0;
      end else if (take) begin
         work_v     <= bat_v;
         work_mask  <= bat_mask;
         work_ts    <= bat_ts;
         work_state <= bat_state;
      end else if (acc) begin
         work_mask  <= rest;
      end
   end
endmodule

// File: rtl/edge_stamper.sv
module edge_stamper
   import edge_stamper_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int FILT_LEN = 4,
   parameter int TS_W     = 48
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    din,
   input  logic [2*NUM_CH-1:0]  edge_en,
   input  logic                 mark_req,
   input  logic [TS_W-1:0]      ts_now,
   output logic                 m_valid,
   input  logic                 m_ready,
   output logic [MSG_W-1:0]     m_data
);
   localparam int SLOT_W = 2*NUM_CH + 1;

   generate
      if (NUM_CH < 1 || NUM_CH > STATE_FW) begin : g_bad_ch
         $error("edge_stamper: NUM_CH must lie in 1..4");
      end
      if (FILT_LEN < 1) begin : g_bad_filt
         $error("edge_stamper: FILT_LEN must be at least 1");
      end
      if (TS_W < 1 || TS_W > TS_FW) begin : g_bad_ts
         $error("edge_stamper: TS_W must lie in 1..48");
      end
   endgenerate

   logic [NUM_CH-1:0] lvl;
   logic [NUM_CH-1:0] rise;
   logic [NUM_CH-1:0] fall;
   logic              take;
   logic              bat_v;
   logic [SLOT_W-1:0] bat_mask;
   logic [TS_W-1:0]   bat_ts;
   logic [NUM_CH-1:0] bat_state;

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         es_deglitch #(.FILT_LEN(FILT_LEN)) u_flt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (din[k]),
            .level (lvl[k]),
            .rise  (rise[k]),
            .fall  (fall[k])
         );
      end
   endgenerate

   es_capture #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .fall      (fall),
      .lvl       (lvl),
      .edge_en   (edge_en),
      .mark_req  (mark_req),
      .ts_now    (ts_now),
      .take      (take),
      .bat_v     (bat_v),
      .bat_mask  (bat_mask),
      .bat_ts    (bat_ts),
      .bat_state (bat_state)
   );

   es_serial #(.NUM_CH(NUM_CH), .TS_W(TS_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .bat_v     (bat_v),
      .bat_mask  (bat_mask),
      .bat_ts    (bat_ts),
      .bat_state (bat_state),
      .take      (take),
      .m_valid   (m_valid),
      .m_ready   (m_ready),
      .m_data    (m_data)
   );
endmodule

// File: rtl/edge_stamper_chk.sv
module edge_stamper_chk #(
   parameter int NUM_CH   = 4,
   parameter int FILT_LEN = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_CH-1:0] din,
   input logic [NUM_CH-1:0] lvl,
   input logic              m_valid,
   input logic              m_ready,
   input logic [63:0]       m_data
);
   localparam int RUN_W = $clog2(FILT_LEN + 1) + 1;

   logic [NUM_CH-1:0] din_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) din_prev <= '0;
      else        din_prev <= din;
   end

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_run
         logic [RUN_W-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               run <= '0;
            else if (din[k] != din_prev[k])
               run <= RUN_W'(1);
            else if (run < RUN_W'(FILT_LEN))
               run <= run + RUN_W'(1);
         end

         // R2: filtered level only moves after FILT_LEN steady samples
         p_filter_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(lvl[k]) |-> (run >= RUN_W'(FILT_LEN)));
      end
   endgenerate

   wire is_evt = (m_data[63:60] == 4'h2);
   wire is_mrk = (m_data[63:56] == 8'h30);
   wire [3:0] st_sh = m_data[51:48] >> m_data[59:57];

   p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

   p_msg_tag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (is_evt || is_mrk));

   p_reserved_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid |-> (m_data[55:52] == 4'h0));

   p_chan_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && is_evt) |-> (int'(m_data[59:57]) < NUM_CH));

   p_state_agrees_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (m_valid && is_evt) |-> (st_sh[0] == !m_data[56]));
endmodule

bind edge_stamper edge_stamper_chk #(.NUM_CH(NUM_CH), .FILT_LEN(FILT_LEN)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .din     (din),
   .lvl     (lvl),
   .m_valid (m_valid),
   .m_ready (m_ready),
   .m_data  (m_data)
);

// File: tb/edge_stamper_bench.sv
module edge_stamper_bench;
   localparam int NCH = 4;
   localparam int FL  = 4;
   localparam int TSW = 48;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   din = '0;
   logic [2*NCH-1:0] edge_en = '1;
   logic             mark_req = 1'b0;
   logic [TSW-1:0]   ts_cnt = 48'h0000_A5A5_0000;
   logic             m_valid;
   logic             m_ready = 1'b1;
   logic [63:0]      m_data;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];
   logic [NCH-1:0] model = '0;

   always #10 clk = ~clk;
   always @(posedge clk) ts_cnt <= ts_cnt + 48'd1;

   edge_stamper #(.NUM_CH(NCH), .FILT_LEN(FL), .TS_W(TSW)) u_edge_stamper (
      .clk      (clk),
      .rst_n    (rst_n),
      .din      (din),
      .edge_en  (edge_en),
      .mark_req (mark_req),
      .ts_now   (ts_cnt),
      .m_valid  (m_valid),
      .m_ready  (m_ready),
      .m_data   (m_data)
   );

   function automatic logic [63:0] ev_word(int ch, bit f, logic [3:0] st, logic [47:0] ts);
      return {4'h2, 3'(ch), f, 4'h0, st, ts};
   endfunction

   function automatic logic [63:0] mk_word(logic [3:0] st, logic [47:0] ts);
      return {8'h30, 4'h0, st, ts};
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   // monitor: pops the scoreboard on every handshake
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n && m_valid && m_ready) begin
            if (exp_q.size() == 0) begin
               check(0, "R9 R2 unexpected word", m_data, 64'h0);
            end else begin
               logic [63:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(m_data == e, t, m_data, e);
            end
         end
      end
   end

   // driver: new raw level held for 'hold' samples; optional marker in capture cycle
   task automatic apply(logic [NCH-1:0] nd, int hold, bit with_mark, bit drop, string tag);
      logic [47:0] t0;
      logic [NCH-1:0] old;
      old = model;
      @(negedge clk);
      mark_req = 1'b0;
      din = nd;
      t0 = ts_cnt;
      if (hold >= FL) begin
         model = nd;
         if (!drop) begin
            for (int k = 0; k < NCH; k++) begin
               if (nd[k] != old[k]) begin
                  bit f;
                  f = !nd[k];
                  if (edge_en[2*k + int'(f)]) begin
                     exp_q.push_back(ev_word(k, f, nd, t0 + 48'(FL)));
                     tag_q.push_back(tag);
                  end
               end
            end
            if (with_mark) begin
               exp_q.push_back(mk_word(nd, t0 + 48'(FL)));
               tag_q.push_back({tag, " marker"});
            end
         end
      end
      for (int i = 1; i < hold; i++) begin
         @(negedge clk);
         mark_req = (with_mark && i == FL);
      end
   endtask

   task automatic marker_only(string tag);
      @(negedge clk);
      mark_req = 1'b1;
      exp_q.push_back(mk_word(model, ts_cnt));
      tag_q.push_back(tag);
      @(negedge clk);
      mark_req = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic drain(string tag);
      for (int i = 0; i < 300 && exp_q.size() > 0; i++) @(negedge clk);
      repeat (6) @(negedge clk);
      check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(m_valid == 1'b0, "R1 valid in reset", 64'(m_valid), 64'h0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      check(m_valid == 1'b0, "R1 idle after reset", 64'(m_valid), 64'h0);

      apply(4'b0001, 8, 0, 0, "R3 R5 R6 R11 rise ch0");
      apply(4'b0000, 8, 0, 0, "R5 R6 fall ch0");
      apply(4'b1110, 8, 0, 0, "R7 simultaneous rises");
      apply(4'b0000, 8, 1, 0, "R7 R8 falls then marker");
      drain("R7 drained");

      edge_en = 8'b0100_0010;
      apply(4'b1001, 8, 0, 0, "R4 rise ch3 only");
      apply(4'b0000, 8, 0, 0, "R4 fall ch0 only");
      drain("R4 no disabled words");
      edge_en = '1;

      apply(4'b0010, 1, 0, 0, "R2 glitch1");
      apply(4'b0000, 6, 0, 0, "R2");
      apply(4'b0010, 2, 0, 0, "R2 glitch2");
      apply(4'b0000, 6, 0, 0, "R2");
      apply(4'b0010, 3, 0, 0, "R2 glitch3");
      apply(4'b0000, 6, 0, 0, "R2");
      marker_only("R2 R8 state unchanged after glitches");
      drain("R2 no glitch words");

      apply(4'b0100, FL, 0, 0, "R3 minimum pulse rise");
      apply(4'b0000, 8, 0, 0, "R3 minimum pulse fall");
      marker_only("R8 lone marker");
      drain("R3 drained");

      @(negedge clk);
      m_ready = 1'b0;
      apply(4'b0001, 8, 0, 0, "R9 first batch");
      apply(4'b0011, 8, 0, 0, "R9 held batch");
      apply(4'b0111, 8, 0, 1, "R9 dropped");
      begin
         logic [63:0] d1;
         @(negedge clk);
         #1;
         d1 = m_data;
         check(m_valid == 1'b1, "R10 valid held", 64'(m_valid), 64'h1);
         repeat (3) @(negedge clk);
         #1;
         check(m_valid == 1'b1 && m_data == d1, "R10 data held", m_data, d1);
      end
      @(negedge clk);
      m_ready = 1'b1;
      drain("R9 two batches out");
      apply(4'b0000, 8, 0, 0, "R9 R11 after drop");
      drain("R9 final");

      finished = 1;
      report();
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog R1 actual=hung expected=done");
         report();
         $finish;
      end
   end
endmodule